// File: doc/BRIEF.md
# Linked-List Descriptor Fetcher

This block drives one DMA channel from a chain of descriptors held in memory. Each descriptor is eight consecutive data words laid out exactly like the channel's own register set: general config, port config, read address, write address, transfer size, next-node pointer, completed-command count and control. Software writes the address of the first descriptor into the node register and then sets the list-enable bit in the control register. The fetcher then reads the eight words one at a time over a single-outstanding word-read port and copies each word into the channel register image. Once all eight words are held, it starts the transfer sequencer.

When the sequencer reports completion, the fetcher follows the loaded next-node pointer. A zero pointer ends the walk and clears list-enable. A pointer back to the head descriptor makes the list repeat until software cancels it. Two one-cycle event strobes mark each descriptor load and each completed command. A write with the cancel bit stops the walk at any point.

Top module: `lldf_fetcher`

## Requirements
- R1: While reset is high and in the first cycle after it, mem_req, seq_start, ev_loaded, ev_done and list_en are all 0, and ch_desc is all zeros.
- R2: When idle, writing index 5 stores the head address. A later write to index 7 with bit 4 set and bit 20 clear then raises list_en in the next cycle, and in that same cycle a read is issued at the head address.
- R3: The eight descriptor words are read at base + 4*k for k = 0..7, in order, with one read outstanding at a time. mem_req is a one-cycle pulse, and the next read is issued in the cycle after mem_rvalid returns the previous word.
- R4: The word returned for k is held in ch_desc[32k+31:32k]. seq_start and ev_loaded pulse together for one cycle, in the cycle after the eighth word is accepted.
- R5: A seq_done seen while the loaded command runs gives a one-cycle ev_done pulse in the next cycle.
- R6: If the loaded word 5 (the next-node pointer) is non-zero when seq_done is seen, the first read of the next descriptor is issued at that address in the next cycle.
- R7: If word 5 is zero when seq_done is seen, list_en falls in the same cycle that ev_done pulses, and no further reads are issued.
- R8: A chain whose last node points back to the head keeps loading and running descriptors with list_en held at 1.
- R9: A write to index 7 with bit 20 set stops the walk in the next cycle: list_en goes to 0, and no further reads or events follow. Bit 20 takes priority over bit 4 in the same write, and data returned after a cancel is discarded.
- R10: A start is ignored when the head address is zero, and while a walk is active.
- R11: After each start, the first event strobe is ev_loaded, not ev_done.
- R12: seq_done has no effect unless a loaded command is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_widx | input | 3 | Register word index (5 node, 7 control) |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Word read request pulse |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rdata | input | 32 | Returned read word |
| mem_rvalid | input | 1 | mem_rdata valid strobe |
| ch_desc | output | 256 | Loaded channel register image, word k at bits 32k+31:32k |
| seq_start | output | 1 | Start pulse to the transfer sequencer |
| seq_done | input | 1 | Command-complete strobe from the sequencer |
| ev_loaded | output | 1 | Descriptor-loaded event pulse |
| ev_done | output | 1 | Command-complete event pulse |
| list_en | output | 1 | List walk active |

## Verification
Each result is due at a fixed number of edges after the input that causes it:
- A control write shows in list_en and mem_req one cycle after the write is sampled.
- A returned word shows in ch_desc one cycle later, and the next read is issued in that same cycle.
- seq_start and ev_loaded follow the eighth word by exactly one cycle.
- ev_done and the first read of the next node follow seq_done by one cycle.

A behavioural model in the bench advances on each rising edge from the same sampled inputs. Every falling edge compares all outputs against the model, so each offset is checked exactly rather than within a window. The directed checks run only after the model-timed waits have settled.

// File: rtl/lldf_pkg.sv
package lldf_pkg;

    localparam int DESC_WORDS  = 8;
    localparam int NODE_WORD   = 5;
    localparam int CTRL_WORD   = 7;
    localparam int LIST_EN_BIT = 4;
    localparam int CANCEL_BIT  = 20;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_ISSUE,
        WS_WAIT,
        WS_LOADED,
        WS_RUN
    } walk_state_e;

    typedef struct packed {
        logic start;
        logic cancel;
        logic node_wr;
    } cfg_cmd_t;

    function automatic cfg_cmd_t decode_cfg(
        input logic we,
        input logic is_node,
        input logic is_ctrl,
        input logic en_bit,
        input logic cancel_bit
    );
        cfg_cmd_t c;
        c.node_wr = we && is_node;
        c.cancel  = we && is_ctrl && cancel_bit;
        c.start   = we && is_ctrl && en_bit && !cancel_bit;
        return c;
    endfunction

endpackage

// File: rtl/lldf_desc_store.sv
module lldf_desc_store
    import lldf_pkg::*;
#(
    parameter int DW    = 32,
    parameter int WORDS = DESC_WORDS,
    parameter int IDXW  = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic                capture,
    input  logic [DW-1:0]       rdata,
    output logic [IDXW-1:0]     word_idx,
    output logic                last_word,
    output logic [WORDS*DW-1:0] desc_flat,
    output logic [DW-1:0]       next_ptr
);

    logic [IDXW-1:0] idx_q;

    assign word_idx  = idx_q;
    assign last_word = (idx_q == IDXW'(WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            idx_q <= '0;
        end else if (capture) begin
            idx_q <= last_word ? '0 : idx_q + 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < WORDS; g++) begin : g_word
            logic [DW-1:0] word_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    word_q <= '0;
                end else if (capture && idx_q == IDXW'(g)) begin
                    word_q <= rdata;
                end
            end
            assign desc_flat[g*DW +: DW] = word_q;
        end
    endgenerate

    assign next_ptr = desc_flat[NODE_WORD*DW +: DW];

endmodule

// File: rtl/lldf_walk_ctrl.sv
module lldf_walk_ctrl
    import lldf_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int WORDS = DESC_WORDS,
    parameter int IDXW  = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            cancel,
    input  logic [DW-1:0]   head,
    input  logic            mem_rvalid,
    input  logic            last_word,
    input  logic [IDXW-1:0] word_idx,
    input  logic [DW-1:0]   next_ptr,
    input  logic            seq_done,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    output logic            restart,
    output logic            capture,
    output logic            seq_start,
    output logic            ev_loaded,
    output logic            ev_done,
    output logic            list_en
);

    localparam int BSH = $clog2(DW / 8);

    walk_state_e   state;
    logic [AW-1:0] base_q;
    logic          list_en_q;
    logic          ev_done_q;
    logic          head_ok;
    logic          next_ok;

    assign head_ok = (head != '0);
    assign next_ok = (next_ptr != '0);

    assign restart = !cancel &&
                     ((state == WS_IDLE && start && head_ok) ||
                      (state == WS_RUN && seq_done && next_ok));
    assign capture = !cancel && state == WS_WAIT && mem_rvalid;

    assign mem_req   = (state == WS_ISSUE);
    assign mem_addr  = base_q + (AW'(word_idx) << BSH);
    assign seq_start = (state == WS_LOADED);
    assign ev_loaded = (state == WS_LOADED);
    assign ev_done   = ev_done_q;
    assign list_en   = list_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= WS_IDLE;
            base_q    <= '0;
            list_en_q <= 1'b0;
            ev_done_q <= 1'b0;
        end else begin
            ev_done_q <= 1'b0;
            if (cancel) begin
                state     <= WS_IDLE;
                list_en_q <= 1'b0;
            end else begin
                unique case (state)
                    WS_IDLE: begin
                        if (start && head_ok) begin
                            state     <= WS_ISSUE;
                            base_q    <= AW'(head);
                            list_en_q <= 1'b1;
                        end
                    end
                    WS_ISSUE: state <= WS_WAIT;
                    WS_WAIT: begin
                        if (mem_rvalid) state <= last_word ? WS_LOADED : WS_ISSUE;
                    end
                    WS_LOADED: state <= WS_RUN;
                    WS_RUN: begin
                        if (seq_done) begin
                            ev_done_q <= 1'b1;
                            if (next_ok) begin
                                state  <= WS_ISSUE;
                                base_q <= AW'(next_ptr);
                            end else begin
                                state     <= WS_IDLE;
                                list_en_q <= 1'b0;
                            end
                        end
                    end
                    default: state <= WS_IDLE;
                endcase
            end
        end
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req); // R3
    AST_START_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
        seq_start |-> $past(mem_rvalid)); // R4
    AST_DONE_FOLLOWS_SEQ: assert property (@(posedge clk) disable iff (rst)
        ev_done |-> $past(seq_done)); // R5
    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> list_en); // R9
    AST_ENABLE_DROP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(list_en) |-> (ev_done || $past(cancel))); // R7

endmodule

// File: rtl/lldf_fetcher.sv
module lldf_fetcher
    import lldf_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int DESC_COUNT = DESC_WORDS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [2:0]               cfg_widx,
    input  logic [DW-1:0]            cfg_wdata,
    output logic                     mem_req,
    output logic [AW-1:0]            mem_addr,
    input  logic [DW-1:0]            mem_rdata,
    input  logic                     mem_rvalid,
    output logic [DESC_COUNT*DW-1:0] ch_desc,
    output logic                     seq_start,
    input  logic                     seq_done,
    output logic                     ev_loaded,
    output logic                     ev_done,
    output logic                     list_en
);

    localparam int IDXW = $clog2(DESC_COUNT);

    cfg_cmd_t        cmd;
    logic [DW-1:0]   node_q;
    logic            restart;
    logic            capture;
    logic            last_word;
    logic [IDXW-1:0] word_idx;
    logic [DW-1:0]   next_ptr;

    assign cmd = decode_cfg(cfg_we,
                            cfg_widx == 3'(NODE_WORD),
                            cfg_widx == 3'(CTRL_WORD),
                            cfg_wdata[LIST_EN_BIT],
                            cfg_wdata[CANCEL_BIT]);

    always_ff @(posedge clk) begin
        if (rst) begin
            node_q <= '0;
        end else if (cmd.node_wr) begin
            node_q <= cfg_wdata;
        end
    end

    lldf_walk_ctrl #(
        .AW(AW), .DW(DW), .WORDS(DESC_COUNT), .IDXW(IDXW)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (cmd.start),
        .cancel     (cmd.cancel),
        .head       (node_q),
        .mem_rvalid (mem_rvalid),
        .last_word  (last_word),
        .word_idx   (word_idx),
        .next_ptr   (next_ptr),
        .seq_done   (seq_done),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .restart    (restart),
        .capture    (capture),
        .seq_start  (seq_start),
        .ev_loaded  (ev_loaded),
        .ev_done    (ev_done),
        .list_en    (list_en)
    );

    lldf_desc_store #(
        .DW(DW), .WORDS(DESC_COUNT), .IDXW(IDXW)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .capture   (capture),
        .rdata     (mem_rdata),
        .word_idx  (word_idx),
        .last_word (last_word),
        .desc_flat (ch_desc),
        .next_ptr  (next_ptr)
    );

endmodule

// File: tb/lldf_fetcher_bench.sv
module lldf_fetcher_bench;

    localparam int FW = 256;
    localparam logic [31:0] EN  = 32'h0000_0010;
    localparam logic [31:0] CAN = 32'h0010_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_widx = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          mem_req;
    logic [31:0]   mem_addr;
    logic [31:0]   mem_rdata = '0;
    logic          mem_rvalid = 1'b0;
    logic [FW-1:0] ch_desc;
    logic          seq_start;
    logic          seq_done = 1'b0;
    logic          ev_loaded;
    logic          ev_done;
    logic          list_en;

    always #5 clk = ~clk;

    lldf_fetcher u_lldf_fetcher (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_widx(cfg_widx),
        .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .ch_desc(ch_desc),
        .seq_start(seq_start), .seq_done(seq_done), .ev_loaded(ev_loaded),
        .ev_done(ev_done), .list_en(list_en)
    );

    int errors = 0;
    int checks = 0;

    task automatic check(input bit ok, input string tag,
                         input logic [FW-1:0] act, input logic [FW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model with programmable latency
    logic [31:0] mem [64];
    int          reads [64];
    bit          pend = 0;
    int          pcnt = 0;
    logic [31:0] paddr = '0;
    int          lat = 1;

    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (pend) begin
            pcnt--;
            if (pcnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem[paddr[7:2]];
                pend       = 0;
            end
        end
        if (!rst && mem_req) begin
            pend  = 1;
            pcnt  = lat;
            paddr = mem_addr;
            reads[mem_addr[7:2]]++;
        end
    end

    // transfer sequencer model
    int run_cnt = 0;
    int run_len = 3;
    bit inject = 0;

    always @(negedge clk) begin
        seq_done = 1'b0;
        if (run_cnt > 0) begin
            run_cnt--;
            if (run_cnt == 0) seq_done = 1'b1;
        end
        if (!rst && seq_start) run_cnt = run_len;
        if (inject) begin
            seq_done = 1'b1;
            inject   = 0;
        end
    end

    // behavioural reference model
    int          ph = 0;
    int          mword = 0;
    logic [31:0] mbase = '0;
    logic [31:0] mnode = '0;
    logic [31:0] mdesc [8];
    bit          men = 0;
    bit          mdone = 0;
    bit          c_can, c_start;

    always @(posedge clk) begin
        if (rst) begin
            ph = 0; mword = 0; mbase = '0; mnode = '0; men = 0; mdone = 0;
            for (int k = 0; k < 8; k++) mdesc[k] = '0;
        end else begin
            mdone   = 0;
            c_can   = cfg_we && cfg_widx == 3'd7 && cfg_wdata[20];
            c_start = cfg_we && cfg_widx == 3'd7 && cfg_wdata[4] && !c_can;
            if (c_can) begin
                ph = 0; men = 0;
            end else begin
                case (ph)
                    0: if (c_start && mnode != 0) begin
                        ph = 1; mbase = mnode; mword = 0; men = 1;
                    end
                    1: ph = 2;
                    2: if (mem_rvalid) begin
                        mdesc[mword] = mem_rdata;
                        if (mword == 7) ph = 3;
                        else begin mword++; ph = 1; end
                    end
                    3: ph = 4;
                    4: if (seq_done) begin
                        mdone = 1;
                        if (mdesc[5] == 0) begin ph = 0; men = 0; end
                        else begin ph = 1; mbase = mdesc[5]; mword = 0; end
                    end
                    default: ph = 0;
                endcase
            end
            if (cfg_we && cfg_widx == 3'd5) mnode = cfg_wdata;
        end
    end

    int n_loaded = 0;
    int n_done = 0;
    bit expect_first = 0;
    logic [FW-1:0] expf;

    always @(negedge clk) begin
        if (!rst) begin
            for (int k = 0; k < 8; k++) expf[k*32 +: 32] = mdesc[k];
            check(mem_req == (ph == 1), "R3 read request", FW'(mem_req), FW'(ph == 1));
            if (ph == 1)
                check(mem_addr == mbase + 32'(mword * 4), "R3 read address",
                      FW'(mem_addr), FW'(mbase + 32'(mword * 4)));
            check(seq_start == (ph == 3), "R4 seq_start", FW'(seq_start), FW'(ph == 3));
            check(ev_loaded == (ph == 3), "R4 ev_loaded", FW'(ev_loaded), FW'(ph == 3));
            check(ch_desc == expf, "R4 register image", ch_desc, expf);
            check(ev_done == mdone, "R5 ev_done", FW'(ev_done), FW'(mdone));
            check(list_en == men, "R7 list_en", FW'(list_en), FW'(men));
            if (expect_first && (ev_loaded || ev_done)) begin
                check(ev_loaded && !ev_done, "R11 first event", FW'({ev_loaded, ev_done}), FW'(2'b10));
                expect_first = 0;
            end
            if (ev_loaded) n_loaded++;
            if (ev_done) n_done++;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic cfg_write(input logic [2:0] idx, input logic [31:0] data);
        cfg_we    = 1'b1;
        cfg_widx  = idx;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] addr, input logic [31:0] nxt);
        for (int k = 0; k < 8; k++)
            mem[addr[7:2] + 6'(k)] = 32'hA000_0000 | (addr << 8) | 32'(k);
        mem[addr[7:2] + 6'd5] = nxt;
        mem[addr[7:2] + 6'd7] = 32'h11;
    endtask

    task automatic clear_stats();
        n_loaded = 0;
        n_done   = 0;
        for (int k = 0; k < 64; k++) reads[k] = 0;
    endtask

    function automatic int total_reads();
        int s = 0;
        for (int k = 0; k < 64; k++) s += reads[k];
        return s;
    endfunction

    task automatic wait_done(input int n);
        int t = 0;
        while (n_done < n && t < 3000) begin
            @(negedge clk);
            t++;
        end
    endtask

    int snap_r, snap_l, snap_d;

    initial begin
        for (int k = 0; k < 64; k++) begin mem[k] = '0; reads[k] = 0; end
        repeat (3) @(negedge clk);
        check(!mem_req && !seq_start && !ev_loaded && !ev_done && !list_en,
              "R1 reset outputs", FW'({mem_req, seq_start, ev_loaded, ev_done, list_en}), '0);
        check(ch_desc == '0, "R1 reset image", ch_desc, '0);
        rst = 1'b0;
        @(negedge clk);
        check(!list_en && !mem_req, "R1 after reset", FW'({list_en, mem_req}), '0);

        // single descriptor, zero next pointer
        lat = 1; run_len = 4;
        put_desc(32'h40, 32'h0);
        clear_stats();
        cfg_write(3'd5, 32'h40);
        expect_first = 1;
        cfg_write(3'd7, EN);
        check(mem_req && list_en, "R2 start", FW'({mem_req, list_en}), FW'(2'b11));
        check(mem_addr == 32'h40, "R2 head address", FW'(mem_addr), FW'(32'h40));
        wait_done(1);
        repeat (3) @(negedge clk);
        check(ch_desc[2*32 +: 32] == 32'hA000_4002, "R4 word 2",
              FW'(ch_desc[2*32 +: 32]), FW'(32'hA000_4002));
        check(!list_en, "R7 end of list", FW'(list_en), '0);
        check(n_loaded == 1 && n_done == 1, "R7 event count",
              FW'({n_loaded[7:0], n_done[7:0]}), FW'(16'h0101));
        snap_r = total_reads();
        repeat (10) @(negedge clk);
        check(total_reads() == snap_r, "R7 no reads after end", FW'(total_reads()), FW'(snap_r));

        // three-node chain
        lat = 3; run_len = 2;
        put_desc(32'h40, 32'h80);
        put_desc(32'h80, 32'hC0);
        put_desc(32'hC0, 32'h0);
        clear_stats();
        cfg_write(3'd5, 32'h40);
        expect_first = 1;
        cfg_write(3'd7, EN);
        wait_done(3);
        repeat (3) @(negedge clk);
        check(n_loaded == 3 && n_done == 3, "R6 chain events",
              FW'({n_loaded[7:0], n_done[7:0]}), FW'(16'h0303));
        check(reads[32] == 1 && reads[48] == 1, "R6 followed pointers",
              FW'({reads[32][7:0], reads[48][7:0]}), FW'(16'h0101));
        check(!list_en, "R7 chain end", FW'(list_en), '0);

        // stray seq_done and a second start while active
        lat = 3; run_len = 5;
        put_desc(32'h40, 32'h0);
        clear_stats();
        inject = 1;
        repeat (4) @(negedge clk);
        check(n_done == 0, "R12 stray done while idle", FW'(n_done), '0);
        cfg_write(3'd5, 32'h40);
        cfg_write(3'd7, EN);
        repeat (3) @(negedge clk);
        inject = 1;
        repeat (2) @(negedge clk);
        cfg_write(3'd5, 32'h80);
        cfg_write(3'd7, EN);
        wait_done(1);
        repeat (3) @(negedge clk);
        check(n_done == 1, "R12 stray done during fetch", FW'(n_done), FW'(1));
        check(n_loaded == 1 && reads[32] == 0, "R10 start while active",
              FW'({n_loaded[7:0], reads[32][7:0]}), FW'(16'h0100));

        // cyclic list, then cancel
        lat = 2; run_len = 3;
        put_desc(32'h20, 32'h60);
        put_desc(32'h60, 32'h20);
        clear_stats();
        cfg_write(3'd5, 32'h20);
        expect_first = 1;
        cfg_write(3'd7, EN);
        wait_done(5);
        check(list_en, "R8 cyclic stays enabled", FW'(list_en), FW'(1));
        check(reads[8] >= 3, "R8 head revisited", FW'(reads[8]), FW'(3));
        cfg_write(3'd7, CAN);
        check(!list_en && !mem_req, "R9 cancel", FW'({list_en, mem_req}), '0);
        repeat (10) @(negedge clk);
        snap_r = total_reads(); snap_l = n_loaded; snap_d = n_done;
        repeat (20) @(negedge clk);
        check(total_reads() == snap_r && n_loaded == snap_l && n_done == snap_d,
              "R9 quiet after cancel", FW'(total_reads()), FW'(snap_r));

        // cancel during fetch, cancel beats enable
        lat = 3;
        put_desc(32'h40, 32'h0);
        clear_stats();
        cfg_write(3'd5, 32'h40);
        cfg_write(3'd7, EN);
        repeat (5) @(negedge clk);
        cfg_write(3'd7, CAN | EN);
        check(!list_en && !mem_req, "R9 cancel over enable", FW'({list_en, mem_req}), '0);
        repeat (20) @(negedge clk);
        check(n_loaded == 0 && n_done == 0, "R9 no load after cancel",
              FW'({n_loaded[7:0], n_done[7:0]}), '0);

        // zero head address
        clear_stats();
        cfg_write(3'd5, 32'h0);
        cfg_write(3'd7, EN);
        check(!list_en && !mem_req, "R10 zero head", FW'({list_en, mem_req}), '0);
        repeat (10) @(negedge clk);
        check(total_reads() == 0, "R10 zero head no reads", FW'(total_reads()), '0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule